// File: doc/BRIEF.md
# Compare Output Waveform Unit

This block is the output stage of one compare channel in a timer. Each timer clock it takes two single-cycle event pulses. The first is the channel's own compare-match event. The second is the timer's period event, which is shared by every channel. From these it drives one registered output pin, according to a 3-bit mode selector.

In the direct mode the pin copies a software-written level. The other seven modes set, clear or toggle the pin when the events arrive. Pairing an action on the match event with an opposite action on the period event gives edge-aligned PWM when the counter counts only up. It gives center-aligned PWM when the counter counts up and down. Counting, comparing and capturing happen outside this block.

Internally the pin level is a two-state machine with states LVL_LOW and LVL_HIGH. A decoder turns the mode and the events into one of five transitions:
- HOLD keeps the current state.
- SET moves to LVL_HIGH.
- CLEAR moves to LVL_LOW.
- TOGGLE moves to the other state.
- LOAD moves to the state named by the software level.

Top module: `cmp_wave_out`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `wave_out` is low (the default idle level).
- R2: With `mode_sel` = 3'b000, `wave_out` after a clock edge equals `sw_level` sampled at that edge. `match_evt` and `period_evt` have no effect in this mode.
- R3: With `mode_sel` = 3'b001, a match event drives `wave_out` high at the next edge. A period event alone leaves it unchanged.
- R4: With `mode_sel` = 3'b101, a match event drives `wave_out` low at the next edge. A period event alone leaves it unchanged.
- R5: With `mode_sel` = 3'b100, a match event inverts `wave_out` at the next edge. A period event alone leaves it unchanged.
- R6: With `mode_sel` = 3'b010, a match event inverts `wave_out` and a period event drives it low.
- R7: With `mode_sel` = 3'b011, a match event drives `wave_out` high and a period event drives it low.
- R8: With `mode_sel` = 3'b110, a match event inverts `wave_out` and a period event drives it high.
- R9: With `mode_sel` = 3'b111, a match event drives `wave_out` low and a period event drives it high.
- R10: When both events arrive in the same cycle, the period action wins in modes 010, 011, 110 and 111. In modes 001, 100 and 101 the match action applies.
- R11: In modes 001 to 111, a cycle with no event leaves `wave_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Output mode selector |
| sw_level | input | 1 | Software-written level used in mode 000 |
| match_evt | input | 1 | Channel compare-match pulse |
| period_evt | input | 1 | Shared period-reached pulse |
| wave_out | output | 1 | Registered output level |

## Verification
Each mode is driven with four event patterns: no event, match only, period only, and both together. These patterns separate the match action from the period action, and they expose the priority rule when both arrive at once. Toggle modes are stepped repeatedly from both starting levels, so a set or clear wrongly decoded as a toggle shows up. Mode 000 is given events while the software level changes, to show that the events are ignored. A long random run then mixes mode switches with every event combination, and a reference model in the bench follows it.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_DIRECT   = 3'b000,
        MODE_SET      = 3'b001,
        MODE_TGL_CLR  = 3'b010,
        MODE_SET_CLR  = 3'b011,
        MODE_TGL      = 3'b100,
        MODE_CLR      = 3'b101,
        MODE_TGL_SET  = 3'b110,
        MODE_CLR_SET  = 3'b111
    } mode_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_SET,
        ACT_CLEAR,
        ACT_TOGGLE,
        ACT_LOAD
    } act_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_t;

endpackage

// File: rtl/owm_action_decode.sv
module owm_action_decode
    import owm_pkg::*;
(
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              match_evt,
    input  logic              period_evt,
    output act_t              act
);

    mode_t mode;
    act_t  match_act;
    act_t  period_act;

    assign mode = mode_t'(mode_sel);

    // action taken on the channel's own match
    always_comb begin
        unique case (mode)
            MODE_DIRECT:  match_act = ACT_LOAD;
            MODE_SET:     match_act = ACT_SET;
            MODE_TGL_CLR: match_act = ACT_TOGGLE;
            MODE_SET_CLR: match_act = ACT_SET;
            MODE_TGL:     match_act = ACT_TOGGLE;
            MODE_CLR:     match_act = ACT_CLEAR;
            MODE_TGL_SET: match_act = ACT_TOGGLE;
            MODE_CLR_SET: match_act = ACT_CLEAR;
            default:      match_act = ACT_HOLD;
        endcase
    end

    // action taken on the shared period event (HOLD = none)
    always_comb begin
        unique case (mode)
            MODE_TGL_CLR,
            MODE_SET_CLR: period_act = ACT_CLEAR;
            MODE_TGL_SET,
            MODE_CLR_SET: period_act = ACT_SET;
            default:      period_act = ACT_HOLD;
        endcase
    end

    // arbitration: direct mode always loads; period beats match
    always_comb begin
        if (mode == MODE_DIRECT)
            act = ACT_LOAD;
        else if (period_evt && period_act != ACT_HOLD)
            act = period_act;
        else if (match_evt)
            act = match_act;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/owm_level_fsm.sv
module owm_level_fsm
    import owm_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  act_t act,
    input  logic sw_level,
    output logic level
);

    lvl_t state;
    lvl_t state_nx;
    lvl_t idle_state;

    generate
        if (IDLE_LEVEL) begin : g_idle_high
            assign idle_state = LVL_HIGH;
        end else begin : g_idle_low
            assign idle_state = LVL_LOW;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= idle_state;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            LVL_LOW: begin
                unique case (act)
                    ACT_SET, ACT_TOGGLE: state_nx = LVL_HIGH;
                    ACT_LOAD:            state_nx = sw_level ? LVL_HIGH : LVL_LOW;
                    default:             state_nx = LVL_LOW;
                endcase
            end
            LVL_HIGH: begin
                unique case (act)
                    ACT_CLEAR, ACT_TOGGLE: state_nx = LVL_LOW;
                    ACT_LOAD:              state_nx = sw_level ? LVL_HIGH : LVL_LOW;
                    default:               state_nx = LVL_HIGH;
                endcase
            end
            default: state_nx = idle_state;
        endcase
    end

    // outputs
    always_comb begin
        level = (state == LVL_HIGH);
    end

endmodule

// File: rtl/cmp_wave_out.sv
module cmp_wave_out
    import owm_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              sw_level,
    input  logic              match_evt,
    input  logic              period_evt,
    output logic              wave_out
);

    act_t act;

    owm_action_decode u_dec (
        .mode_sel   (mode_sel),
        .match_evt  (match_evt),
        .period_evt (period_evt),
        .act        (act)
    );

    owm_level_fsm #(
        .IDLE_LEVEL (IDLE_LEVEL)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .sw_level (sw_level),
        .level    (wave_out)
    );

endmodule

// File: rtl/cmp_wave_out_chk.sv
module cmp_wave_out_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input logic       sw_level,
    input logic       match_evt,
    input logic       period_evt,
    input logic       wave_out
);

    // R2
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 3'b000 |=> wave_out == $past(sw_level));

    // R3
    set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b001 && match_evt) |=> wave_out);

    // R4
    clear_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b101 && match_evt) |=> !wave_out);

    // R5
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b100 && match_evt) |=> wave_out != $past(wave_out));

    // R6
    tglclr_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b010 && period_evt) |=> !wave_out);

    // R9
    clrset_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'b111 && period_evt) |=> wave_out);

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 3'b000 && !match_evt && !period_evt) |=> $stable(wave_out));

endmodule

bind cmp_wave_out cmp_wave_out_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .sw_level   (sw_level),
    .match_evt  (match_evt),
    .period_evt (period_evt),
    .wave_out   (wave_out)
);

// File: tb/sim_cmp_wave_out.sv
`timescale 1ns/1ps
module sim_cmp_wave_out;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       sw_level = 1'b0;
    logic       match_evt = 1'b0;
    logic       period_evt = 1'b0;
    logic       wave_out;

    int  total = 0;
    int  bad = 0;
    bit  exp_lvl = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_wave_out u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .sw_level   (sw_level),
        .match_evt  (match_evt),
        .period_evt (period_evt),
        .wave_out   (wave_out)
    );

    function automatic bit model(input logic [2:0] md, input bit sw,
                                 input bit m, input bit p, input bit cur);
        case (md)
            3'b000: return sw;
            3'b001: return m ? 1'b1 : cur;
            3'b100: return m ? ~cur : cur;
            3'b101: return m ? 1'b0 : cur;
            3'b010: return p ? 1'b0 : (m ? ~cur : cur);
            3'b011: return p ? 1'b0 : (m ? 1'b1 : cur);
            3'b110: return p ? 1'b1 : (m ? ~cur : cur);
            default: return p ? 1'b1 : (m ? 1'b0 : cur);
        endcase
    endfunction

    function automatic string tag(input logic [2:0] md, input bit m, input bit p);
        if (md == 3'b000) return "R2";
        if (!m && !p) return "R11";
        if (m && p) return "R10";
        case (md)
            3'b001: return "R3";
            3'b101: return "R4";
            3'b100: return "R5";
            3'b010: return "R6";
            3'b011: return "R7";
            3'b110: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input bit exp);
        total++;
        if (wave_out !== exp) begin
            bad++;
            $display("FAIL %s: wave_out=%b expected=%b", req, wave_out, exp);
        end
    endtask

    task automatic step(input logic [2:0] md, input bit sw, input bit m, input bit p);
        @(negedge clk);
        mode_sel = md; sw_level = sw; match_evt = m; period_evt = p;
        exp_lvl = model(md, sw, m, p, exp_lvl);
        @(posedge clk);
        #1;
        check(tag(md, m, p), exp_lvl);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog: wave_out=%b expected=finish", wave_out);
        finish_run();
    end

    initial begin
        // R1: reset state, with events present
        match_evt = 1'b1; period_evt = 1'b1; mode_sel = 3'b001;
        repeat (3) @(posedge clk);
        #1 check("R1", 1'b0);
        @(negedge clk);
        match_evt = 1'b0; period_evt = 1'b0; mode_sel = 3'b000;
        rst_n = 1'b1;
        exp_lvl = 1'b0;
        @(posedge clk); #1 check("R1", 1'b0);

        // R2: direct mode ignores events
        step(3'b000, 1'b1, 1'b0, 1'b0);
        step(3'b000, 1'b1, 1'b1, 1'b1);
        step(3'b000, 1'b0, 1'b1, 1'b0);
        step(3'b000, 1'b0, 1'b0, 1'b1);
        // R3: set on match, period alone no effect
        step(3'b001, 1'b0, 1'b0, 1'b1);
        step(3'b001, 1'b0, 1'b1, 1'b0);
        step(3'b001, 1'b0, 1'b1, 1'b1);
        // R4: clear
        step(3'b101, 1'b0, 1'b0, 1'b1);
        step(3'b101, 1'b0, 1'b1, 1'b0);
        // R5: toggle from both levels
        step(3'b100, 1'b0, 1'b1, 1'b0);
        step(3'b100, 1'b0, 1'b1, 1'b0);
        step(3'b100, 1'b0, 1'b0, 1'b1);
        step(3'b100, 1'b0, 1'b1, 1'b1);
        // R6
        step(3'b010, 1'b0, 1'b1, 1'b0);
        step(3'b010, 1'b0, 1'b0, 1'b1);
        step(3'b010, 1'b0, 1'b1, 1'b0);
        step(3'b010, 1'b0, 1'b1, 1'b1);
        // R7
        step(3'b011, 1'b0, 1'b1, 1'b0);
        step(3'b011, 1'b0, 1'b0, 1'b0);
        step(3'b011, 1'b0, 1'b1, 1'b1);
        step(3'b011, 1'b0, 1'b1, 1'b0);
        step(3'b011, 1'b0, 1'b0, 1'b1);
        // R8
        step(3'b110, 1'b0, 1'b0, 1'b1);
        step(3'b110, 1'b0, 1'b1, 1'b0);
        step(3'b110, 1'b0, 1'b1, 1'b1);
        // R9
        step(3'b111, 1'b0, 1'b1, 1'b0);
        step(3'b111, 1'b0, 1'b0, 1'b1);
        step(3'b111, 1'b0, 1'b1, 1'b0);
        step(3'b111, 1'b0, 1'b1, 1'b1);
        step(3'b111, 1'b0, 1'b0, 1'b0);

        // random mix
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] md;
            md = 3'($urandom_range(0, 7));
            step(md, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        finish_run();
    end

endmodule